// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block takes a serial line, finds the start of each character and samples it against a sixteen-times oversampling tick that comes from outside. It shifts the data, parity and stop bits into a receive shift register. At the middle of the last stop bit it moves the finished character into a receive buffer register, which the host later reads. Character length (7, 8 or 9 bits), parity (none, even or odd) and the number of stop bits (one or two) are static inputs. They are set to match the far-end transmitter.

Each character is checked for three kinds of error: a parity mismatch, a stop bit sampled low, and a new character arriving while the previous one is still unread. One combined flag reports whether any of these is set. A single-cycle interrupt pulse marks each normal transfer into the buffer. An optional request-to-send output lets the far end pause while the buffer is full.

Top module: `uart_rx_core`

## Requirements
- R1: A character is accepted only while `rxEn` is 1, and only after a high-to-low change of the line as seen on two successive ticks. A line that is already low when reception is enabled starts nothing.
- R2: A start candidate is sampled again 8 ticks after detection. If the line is high at that point, the receiver goes back to idle, and the buffer and the interrupt are left untouched.
- R3: Data bits are taken least significant bit first, one every 16 ticks. `dataSel` = 0 selects 7 bits, 1 selects 8 bits, and 2 or 3 selects 9 bits. The character appears right-aligned on `rxData`, with the unused upper bits at zero.
- R4: When a character is transferred to the buffer, `bufFull` becomes 1. `rxIrq` is then high for exactly one cycle, unless the transfer is an overrun.
- R5: When `parityEn` is 1, `parityErr` is set if the count of ones over the data and parity bits is odd while `parityOdd` is 0, or even while `parityOdd` is 1.
- R6: `framingErr` is set when any of the selected stop bits (two if `twoStop` is 1, otherwise one) is sampled low.
- R7: `overrunErr` is set when the last bit before the stop bit is sampled while `bufFull` is 1 and no read is strobed in that cycle. The new character still overwrites the buffer, and no `rxIrq` is raised for it.
- R8: `errSum` is 1 exactly when at least one of `overrunErr`, `framingErr` and `parityErr` is 1.
- R9: The error flags stay set until either `rdStrobe` is asserted or `rxEn` is 0. `rdStrobe` also clears `bufFull`. If a read and a transfer fall in the same cycle, the transfer wins: the buffer stays full, and only the new character's errors (including its own overrun) remain.
- R10: With `rtsEn` = 1, `rtsN` is 0 while reception is enabled and the buffer is empty, and 1 while the buffer holds unread data. With `rtsEn` = 0, `rtsN` is held at 0.
- R11: Dropping `rxEn` in the middle of a character abandons that character. The buffer contents and `bufFull` are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxEn | input | 1 | Receive enable |
| rxd | input | 1 | Serial line input (idle high) |
| dataSel | input | 2 | Character length select: 0 = 7, 1 = 8, 2 or 3 = 9 bits |
| parityEn | input | 1 | Parity bit present and checked |
| parityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| twoStop | input | 1 | 1 = two stop bits, 0 = one stop bit |
| rtsEn | input | 1 | Enable request-to-send flow control |
| rdStrobe | input | 1 | Host read of the buffer |
| rxData | output | 9 | Receive buffer contents |
| bufFull | output | 1 | Buffer holds an unread character |
| rxIrq | output | 1 | Receive interrupt pulse |
| overrunErr | output | 1 | Overrun flag |
| framingErr | output | 1 | Framing flag |
| parityErr | output | 1 | Parity flag |
| errSum | output | 1 | OR of the three error flags |
| rtsN | output | 1 | Request-to-send, active low |

## Verification
Two events can land in the same cycle: a host read, and the buffer write at the middle of the last stop bit. The bench sets this up as follows. It first leaves a character with a framing error unread. It then sends a second character with bad parity, waits for the overrun flag to rise at that character's parity sample, and strobes the read exactly 64 clocks (16 ticks) later. It then expects the new data in a still-full buffer, the old framing flag cleared, the parity and overrun flags set, and no interrupt.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_MAX = 9;
  localparam int LEN_W    = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rxState_t;

  // strobes from control to datapath, each valid for one clock
  typedef struct packed {
    logic shiftIn;      // sample a data bit
    logic sampleParity; // sample the parity bit
    logic preStop;      // the bit before the first stop bit was just sampled
    logic stopSample;   // sample a stop bit
    logic load;         // final stop bit: move character to buffer
  } rxStrobe_t;

  function automatic logic [LEN_W-1:0] charLen(input logic [1:0] sel);
    case (sel)
      2'd0:    charLen = LEN_W'(DATA_MAX - 2);
      2'd1:    charLen = LEN_W'(DATA_MAX - 1);
      default: charLen = LEN_W'(DATA_MAX);
    endcase
  endfunction
endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxEn,
  input  logic       rxS,
  input  logic [1:0] dataSel,
  input  logic       parityEn,
  input  logic       twoStop,
  output rxStrobe_t  strb
);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] HALF_TICK = CNT_W'(OVS / 2 - 1);

  rxState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [LEN_W-1:0] bitCnt;
  logic             stopCnt;
  logic             prevHigh;
  logic [LEN_W-1:0] nBits;
  logic             midPoint;
  logic             lastData;
  logic             lastStop;

  assign nBits    = charLen(dataSel);
  assign midPoint = tick && (tickCnt == LAST_TICK);
  assign lastData = (bitCnt == nBits - LEN_W'(1));
  assign lastStop = !twoStop || stopCnt;

  always_comb begin
    strb = '0;
    if (rxEn && midPoint) begin
      case (state)
        ST_DATA: begin
          strb.shiftIn = 1'b1;
          strb.preStop = lastData && !parityEn;
        end
        ST_PAR: begin
          strb.sampleParity = 1'b1;
          strb.preStop      = 1'b1;
        end
        ST_STOP: begin
          strb.stopSample = 1'b1;
          strb.load       = lastStop;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tickCnt  <= '0;
      bitCnt   <= '0;
      stopCnt  <= 1'b0;
      prevHigh <= 1'b0;
    end else if (!rxEn) begin
      state    <= ST_IDLE;
      tickCnt  <= '0;
      prevHigh <= 1'b0;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          prevHigh <= rxS;
          tickCnt  <= '0;
          if (prevHigh && !rxS) state <= ST_START;
        end
        ST_START: begin
          if (tickCnt == HALF_TICK) begin
            tickCnt <= '0;
            bitCnt  <= '0;
            if (rxS) begin
              state    <= ST_IDLE;
              prevHigh <= 1'b1;
            end else begin
              state <= ST_DATA;
            end
          end else begin
            tickCnt <= tickCnt + CNT_W'(1);
          end
        end
        ST_DATA: begin
          tickCnt <= midPoint ? '0 : tickCnt + CNT_W'(1);
          if (midPoint) begin
            bitCnt <= bitCnt + LEN_W'(1);
            if (lastData) begin
              state   <= parityEn ? ST_PAR : ST_STOP;
              stopCnt <= 1'b0;
            end
          end
        end
        ST_PAR: begin
          tickCnt <= midPoint ? '0 : tickCnt + CNT_W'(1);
          if (midPoint) begin
            state   <= ST_STOP;
            stopCnt <= 1'b0;
          end
        end
        ST_STOP: begin
          tickCnt <= midPoint ? '0 : tickCnt + CNT_W'(1);
          if (midPoint) begin
            if (lastStop) begin
              state    <= ST_IDLE;
              prevHigh <= rxS;
            end else begin
              stopCnt <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_dp.sv
module uart_rx_dp
  import uart_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxEn,
  input  logic                rxS,
  input  rxStrobe_t           strb,
  input  logic [1:0]          dataSel,
  input  logic                parityEn,
  input  logic                parityOdd,
  input  logic                rdStrobe,
  output logic [DATA_MAX-1:0] rxData,
  output logic                bufFull,
  output logic                rxIrq,
  output logic                ovrErr,
  output logic                frmErr,
  output logic                parErr
);
  logic [DATA_MAX-1:0] shiftReg;
  logic [DATA_MAX-1:0] aligned;
  logic [LEN_W-1:0]    nBits;
  logic                parBit;
  logic                frameBad;
  logic                ovrPend;
  logic                onesOdd;
  logic                parFail;
  logic                frameFail;
  logic                clrFlags;
  logic                ovrNow;

  assign nBits     = charLen(dataSel);
  assign aligned   = shiftReg >> (LEN_W'(DATA_MAX) - nBits);
  assign onesOdd   = (^aligned) ^ parBit;
  assign parFail   = parityEn && (parityOdd ? !onesOdd : onesOdd);
  assign frameFail = frameBad || !rxS;
  assign clrFlags  = rdStrobe || !rxEn;
  assign ovrNow    = strb.preStop && bufFull && !rdStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
      frameBad <= 1'b0;
      ovrPend  <= 1'b0;
    end else begin
      if (strb.shiftIn)      shiftReg <= {rxS, shiftReg[DATA_MAX-1:1]};
      if (strb.sampleParity) parBit   <= rxS;
      if (strb.preStop) begin
        frameBad <= 1'b0;
        ovrPend  <= ovrNow;
      end else if (strb.stopSample && !rxS) begin
        frameBad <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      bufFull <= 1'b0;
      rxIrq   <= 1'b0;
      ovrErr  <= 1'b0;
      frmErr  <= 1'b0;
      parErr  <= 1'b0;
    end else begin
      rxIrq  <= strb.load && !ovrPend;
      ovrErr <= (ovrErr && !clrFlags) || ovrNow || (strb.load && ovrPend);
      frmErr <= (frmErr && !clrFlags) || (strb.load && frameFail);
      parErr <= (parErr && !clrFlags) || (strb.load && parFail);
      if (strb.load) begin
        rxData  <= aligned;
        bufFull <= 1'b1;
      end else if (rdStrobe) begin
        bufFull <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int SYNC_LEN  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic                rxEn,
  input  logic                rxd,
  input  logic [1:0]          dataSel,
  input  logic                parityEn,
  input  logic                parityOdd,
  input  logic                twoStop,
  input  logic                rtsEn,
  input  logic                rdStrobe,
  output logic [DATA_MAX-1:0] rxData,
  output logic                bufFull,
  output logic                rxIrq,
  output logic                overrunErr,
  output logic                framingErr,
  output logic                parityErr,
  output logic                errSum,
  output logic                rtsN
);
  logic [SYNC_LEN-1:0] syncReg;
  logic                rxS;
  rxStrobe_t           strb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg <= '1;
    else       syncReg <= {syncReg[SYNC_LEN-2:0], rxd};
  end
  assign rxS = syncReg[SYNC_LEN-1];

  uart_rx_ctrl #(.OVS(OVS)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .rxEn(rxEn), .rxS(rxS),
    .dataSel(dataSel), .parityEn(parityEn), .twoStop(twoStop), .strb(strb)
  );

  uart_rx_dp uDp (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .rxS(rxS), .strb(strb),
    .dataSel(dataSel), .parityEn(parityEn), .parityOdd(parityOdd),
    .rdStrobe(rdStrobe), .rxData(rxData), .bufFull(bufFull), .rxIrq(rxIrq),
    .ovrErr(overrunErr), .frmErr(framingErr), .parErr(parityErr)
  );

  assign errSum = overrunErr || framingErr || parityErr;
  assign rtsN   = rtsEn ? !(rxEn && !bufFull) : 1'b0;
endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker (
  input logic clk,
  input logic rstN,
  input logic rxEn,
  input logic rtsEn,
  input logic rdStrobe,
  input logic rxIrq,
  input logic bufFull,
  input logic overrunErr,
  input logic framingErr,
  input logic parityErr,
  input logic errSum,
  input logic rtsN
);
  assert_irq_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> bufFull);
  assert_irq_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);
  assert_ovr_needs_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunErr) |-> $past(bufFull));
  assert_sum_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(parityErr) || $rose(framingErr) || $rose(overrunErr)) |-> errSum);
  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> !(overrunErr || framingErr || parityErr));
  assert_read_empties_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> (!bufFull || rxIrq || overrunErr));
  assert_rts_full_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rtsEn && bufFull) |-> rtsN);
  assert_rts_ready_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rtsEn && rxEn && !bufFull) |-> !rtsN);
endmodule

bind uart_rx_core uart_rx_checker uChk (
  .clk(clk), .rstN(rstN), .rxEn(rxEn), .rtsEn(rtsEn), .rdStrobe(rdStrobe),
  .rxIrq(rxIrq), .bufFull(bufFull), .overrunErr(overrunErr),
  .framingErr(framingErr), .parityErr(parityErr), .errSum(errSum), .rtsN(rtsN)
);

// File: tb/tb_uart_rx_core.sv
`timescale 1ns/1ps
module tb_uart_rx_core;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       rxEn = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] dataSel = 2'd1;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       twoStop = 1'b0;
  logic       rtsEn = 1'b0;
  logic       rdStrobe = 1'b0;
  logic [8:0] rxData;
  logic       bufFull, rxIrq, overrunErr, framingErr, parityErr, errSum, rtsN;

  int checks = 0;
  int errors = 0;
  int irqCount = 0;
  bit done = 0;

  // model state
  bit       mFull = 0;
  bit [8:0] mData = 0;
  bit       mOvr = 0, mFrm = 0, mPar = 0;
  int       mIrq = 0;

  uart_rx_core dut (
    .clk(clk), .rstN(rstN), .tick(tick), .rxEn(rxEn), .rxd(rxd),
    .dataSel(dataSel), .parityEn(parityEn), .parityOdd(parityOdd),
    .twoStop(twoStop), .rtsEn(rtsEn), .rdStrobe(rdStrobe), .rxData(rxData),
    .bufFull(bufFull), .rxIrq(rxIrq), .overrunErr(overrunErr),
    .framingErr(framingErr), .parityErr(parityErr), .errSum(errSum), .rtsN(rtsN)
  );

  always #4 clk = ~clk;

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      tick = (div == 3);
      div = (div + 1) % 4;
    end
  end

  always @(negedge clk) if (rstN && rxIrq) irqCount++;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lenOf(input bit [1:0] sel);
    return (sel == 2'd0) ? 7 : (sel == 2'd1) ? 8 : 9;
  endfunction

  function automatic bit [8:0] maskData(input bit [8:0] d, input bit [1:0] sel);
    return d & 9'((1 << lenOf(sel)) - 1);
  endfunction

  function automatic bit goodParity(input bit [8:0] d, input bit odd);
    return odd ? ~^d : ^d;
  endfunction

  task automatic holdBit(input bit v);
    rxd = v;
    repeat (64) @(negedge clk);
  endtask

  task automatic sendFrame(input bit [8:0] d, input bit badPar, input bit [1:0] badStop);
    bit [8:0] md;
    md = maskData(d, dataSel);
    holdBit(1'b0);
    for (int i = 0; i < lenOf(dataSel); i++) holdBit(md[i]);
    if (parityEn) holdBit(goodParity(md, parityOdd) ^ badPar);
    holdBit(!badStop[0]);
    if (twoStop) holdBit(!badStop[1]);
    holdBit(1'b1);
  endtask

  // model of a completed frame with enable on and no read during it
  task automatic modelFrame(input bit [8:0] d, input bit badPar, input bit [1:0] badStop);
    bit ovr;
    ovr = mFull;
    mOvr |= ovr;
    mFrm |= twoStop ? (badStop != 0) : badStop[0];
    mPar |= parityEn & badPar;
    mData = maskData(d, dataSel);
    mFull = 1;
    if (!ovr) mIrq++;
  endtask

  task automatic hostRead();
    @(negedge clk); rdStrobe = 1'b1;
    @(negedge clk); rdStrobe = 1'b0;
    mFull = 0; mOvr = 0; mFrm = 0; mPar = 0;
  endtask

  task automatic checkAll(input string tag);
    check({tag, " R3 data"}, rxData, mData);
    check({tag, " R4 bufFull"}, bufFull, mFull);
    check({tag, " R4 irq count"}, irqCount, mIrq);
    check({tag, " R7 overrun"}, overrunErr, mOvr);
    check({tag, " R6 framing"}, framingErr, mFrm);
    check({tag, " R5 parity"}, parityErr, mPar);
    check({tag, " R8 sum"}, errSum, mOvr | mFrm | mPar);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // reset state
    check("R4 reset bufFull", bufFull, 0);
    check("R8 reset errSum", errSum, 0);
    check("R10 reset rtsN", rtsN, 0);
    rstN = 1'b1;
    repeat (8) @(negedge clk);

    // R1: frame while disabled is ignored
    sendFrame(9'h0A5, 0, 2'b00);
    checkAll("R1 disabled");

    rxEn = 1'b1;
    repeat (40) @(negedge clk);

    // R2: short glitch is rejected
    rxd = 1'b0; repeat (12) @(negedge clk);
    rxd = 1'b1; repeat (120) @(negedge clk);
    checkAll("R2 glitch");

    // R10: flow control
    rtsEn = 1'b1; @(negedge clk);
    check("R10 rts empty", rtsN, 0);
    dataSel = 2'd1; parityEn = 0; twoStop = 0;
    sendFrame(9'h03C, 0, 2'b00); modelFrame(9'h03C, 0, 2'b00);
    checkAll("R1 first frame");
    check("R10 rts full", rtsN, 1);
    hostRead(); @(negedge clk);
    check("R9 read empties", bufFull, 0);
    check("R10 rts after read", rtsN, 0);
    rtsEn = 1'b0; @(negedge clk);
    check("R10 rts disabled", rtsN, 0);

    // random frames across formats and error injections
    for (int n = 0; n < 40; n++) begin
      bit [8:0] d;
      bit bp;
      bit [1:0] bs;
      dataSel   = 2'($urandom % 4);
      parityEn  = 1'($urandom);
      parityOdd = 1'($urandom);
      twoStop   = 1'($urandom);
      d  = 9'($urandom);
      bp = ($urandom % 5) == 0;
      bs = (($urandom % 5) == 0) ? 2'(1 + $urandom % 3) : 2'b00;
      sendFrame(d, bp, bs);
      modelFrame(d, bp, bs);
      checkAll("R3 random");
      if ($urandom % 2) hostRead();
      @(negedge clk);
    end

    // R7 and R9: overrun with a read landing on the transfer cycle
    hostRead();
    dataSel = 2'd1; parityEn = 1; parityOdd = 0; twoStop = 0;
    sendFrame(9'h055, 0, 2'b01); modelFrame(9'h055, 0, 2'b01);
    checkAll("R6 before overrun");
    fork
      sendFrame(9'h0C3, 1, 2'b00);
      begin
        while (!overrunErr) @(negedge clk);
        repeat (63) @(posedge clk);
        @(negedge clk) rdStrobe = 1'b1;
        @(negedge clk) rdStrobe = 1'b0;
      end
    join
    mData = 9'h0C3; mFull = 1; mFrm = 0; mPar = 1; mOvr = 1;
    checkAll("R9 read with transfer");

    // R11: disable mid-frame keeps buffer, clears flags
    fork
      sendFrame(9'h1FF, 0, 2'b00);
      begin
        repeat (200) @(negedge clk);
        rxEn = 1'b0;
      end
    join
    repeat (4) @(negedge clk);
    mOvr = 0; mFrm = 0; mPar = 0;
    checkAll("R11 abort");
    rxEn = 1'b1;
    repeat (40) @(negedge clk);
    check("R11 still full", bufFull, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule